// File: doc/BRIEF.md
# Counter-Bit Interval Trigger Generator

This block produces periodic start pulses for an A/D converter and periodic interrupt requests. It does this by watching four bits (6, 7, 8 and 9) of a free-running 16-bit timer counter for 0-to-1 transitions. Each of these bits rises once every 2^(n+1) counts. Enabling the rising edge of a given bit therefore selects a fixed period, and no compare-match register is needed.

An 8-bit control register holds the enables. Its upper nibble gates the converter start for each monitored bit, and its lower nibble gates the interrupt for the same bits. Software reads and writes the register through a plain write-enable and data port, and the current contents are always visible on the read port. The converter trigger is a one-cycle pulse. The interrupt is a sticky flag that software clears with a write-one strobe. A standby input resets the register and silences both outputs.

Top module: `interval_trigger_gen`

## Requirements
- R1: After a synchronous reset the control register reads 0x00. A write stores all eight bits, and the stored value is seen on `ctrl_rd_data` in the cycle after the write.
- R2: Register bit 4+k (k = 0..3) enables converter starts from counter bit 6+k. If bit 6+k is 0 in one cycle and 1 in the next while the enable is set, `adc_start_o` is high for exactly one cycle, in the cycle after the clock edge that samples the new counter value.
- R3: Register bit k (k = 0..3) enables interrupts from counter bit 6+k. An enabled rising edge sets `irq_o` in the cycle after the edge is sampled.
- R4: When the matching enable bit is 0, a rising edge of a monitored bit causes neither a converter start nor an interrupt.
- R5: While `standby_i` is high, the register is forced to 0x00, `irq_o` is cleared and no converter start is issued.
- R6: `irq_o` stays high until `irq_clr_i` is sampled high. If a new enabled interrupt edge arrives in the same cycle as the clear, the flag stays set.
- R7: If several enabled bits rise in the same cycle, `adc_start_o` is high for only one cycle.
- R8: An edge sampled in the same cycle as a register write is gated by the enable value from before the write.
- R9: When the counter wraps from 0xFFFF to 0x0000, neither output fires, even with all enables set.
- R10: A monitored bit that stays high yields only the single pulse from its rise, not one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby request; clears the register and silences the outputs |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 8 | Control register write data |
| ctrl_rd_data | output | 8 | Control register contents |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| cnt_i | input | 16 | Free-running timer counter value |
| adc_start_o | output | 1 | One-cycle converter start pulse |
| irq_o | output | 1 | Sticky interval interrupt request |

## Verification
The counter is stepped by one per cycle across several hundred counts. This separates an edge detector from a level detector, because bit 6 stays high for 64 cycles after each rise. Jumps of the counter make all four bits rise at once, and a step across 0xFFFF to 0x0000 makes them all fall at once. These show that coincident edges merge into one pulse and that falling edges are ignored. Register writes placed in the same cycle as an edge tell old-enable gating apart from new-enable gating. Clears placed in the same cycle as an interrupt edge tell set priority apart from clear priority. A standby pulse with every enable set shows that it clears the register and the flag together.

// File: rtl/itg_pkg.sv
package itg_pkg;
    localparam int CNT_W    = 16;
    localparam int TAP_LO   = 6;
    localparam int TAPS     = 4;
    localparam int CTRL_W   = 2 * TAPS;

    typedef logic [TAPS-1:0] tap_vec_t;

    typedef struct packed {
        tap_vec_t adc_en;
        tap_vec_t irq_en;
    } ctrl_t;

    function automatic logic any_gated(input tap_vec_t rise, input tap_vec_t en);
        return |(rise & en);
    endfunction
endpackage

// File: rtl/itg_ctrl_reg.sv
module itg_ctrl_reg
    import itg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              standby_i,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst || standby_i) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data);
        end
    end
endmodule

// File: rtl/itg_edge_det.sv
module itg_edge_det #(
    parameter int CW   = 16,
    parameter int LO   = 6,
    parameter int NT   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    output logic [NT-1:0] rise
);
    logic [NT-1:0] prev_q;

    for (genvar k = 0; k < NT; k++) begin : g_tap
        assign rise[k] = cnt[LO+k] & ~prev_q[k];

        always_ff @(posedge clk) begin
            if (rst) prev_q[k] <= 1'b0;
            else     prev_q[k] <= cnt[LO+k];
        end
    end
endmodule

// File: rtl/itg_trig_out.sv
module itg_trig_out
    import itg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     standby_i,
    input  tap_vec_t rise,
    input  ctrl_t    ctrl,
    input  logic     irq_clr,
    output logic     adc_start,
    output logic     irq
);
    logic adc_hit, irq_hit;

    always_comb begin
        adc_hit = any_gated(rise, ctrl.adc_en);
        irq_hit = any_gated(rise, ctrl.irq_en);
    end

    always_ff @(posedge clk) begin
        if (rst || standby_i) begin
            adc_start <= 1'b0;
            irq       <= 1'b0;
        end else begin
            adc_start <= adc_hit;
            if (irq_hit)      irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/interval_trigger_gen.sv
module interval_trigger_gen
    import itg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              standby_i,
    input  logic              ctrl_wr_en,
    input  logic [CTRL_W-1:0] ctrl_wr_data,
    output logic [CTRL_W-1:0] ctrl_rd_data,
    input  logic              irq_clr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              adc_start_o,
    output logic              irq_o
);
    ctrl_t    ctrl_q;
    tap_vec_t rise;

    itg_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .standby_i (standby_i),
        .wr_en     (ctrl_wr_en),
        .wr_data   (ctrl_wr_data),
        .ctrl_q    (ctrl_q)
    );

    itg_edge_det #(.CW(CNT_W), .LO(TAP_LO), .NT(TAPS)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt_i),
        .rise (rise)
    );

    itg_trig_out u_out (
        .clk       (clk),
        .rst       (rst),
        .standby_i (standby_i),
        .rise      (rise),
        .ctrl      (ctrl_q),
        .irq_clr   (irq_clr_i),
        .adc_start (adc_start_o),
        .irq       (irq_o)
    );

    assign ctrl_rd_data = ctrl_q;
endmodule

// File: rtl/itg_checker.sv
module itg_checker
    import itg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              standby_i,
    input logic              irq_clr_i,
    input logic [CTRL_W-1:0] ctrl_rd_data,
    input logic              adc_start_o,
    input logic              irq_o
);
    // R1: reset leaves the register empty
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> ctrl_rd_data == '0);

    // R5: standby clears register and outputs
    a_r5_standby_clear: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> (ctrl_rd_data == '0) && !irq_o && !adc_start_o);

    // R2/R4: a start pulse needs a converter enable in the sampling cycle
    a_r4_adc_needs_enable: assert property (@(posedge clk) disable iff (rst)
        adc_start_o |-> $past(ctrl_rd_data[CTRL_W-1:TAPS]) != '0);

    // R3/R4: the flag rises only if an interrupt enable was set
    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(ctrl_rd_data[TAPS-1:0]) != '0);

    // R6: the flag holds without a clear or standby
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_o && !irq_clr_i && !standby_i |=> irq_o);
endmodule

bind interval_trigger_gen itg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .standby_i    (standby_i),
    .irq_clr_i    (irq_clr_i),
    .ctrl_rd_data (ctrl_rd_data),
    .adc_start_o  (adc_start_o),
    .irq_o        (irq_o)
);

// File: tb/tb_interval_trigger_gen.sv
module tb_interval_trigger_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby_i = 1'b0;
    logic        ctrl_wr_en = 1'b0;
    logic [7:0]  ctrl_wr_data = 8'h00;
    logic [7:0]  ctrl_rd_data;
    logic        irq_clr_i = 1'b0;
    logic [15:0] cnt_i = 16'h0000;
    logic        adc_start_o;
    logic        irq_o;

    always #10 clk = ~clk;

    interval_trigger_gen dut (.*);

    int     vectors = 0;
    int     errors  = 0;
    int     cycles  = 0;
    string  cur_req = "R1";
    bit     done    = 0;

    // behavioural reference
    bit [7:0] m_reg;
    bit [3:0] m_prev;
    bit       m_adc, m_irq;
    int       adc_pulses = 0;

    task automatic model_step();
        bit adc_n, irq_set;
        adc_n = 0; irq_set = 0;
        for (int k = 0; k < 4; k++) begin
            if (cnt_i[6+k] && !m_prev[k]) begin
                if (m_reg[4+k]) adc_n = 1;
                if (m_reg[k])   irq_set = 1;
            end
        end
        if (rst) begin
            m_reg = 0; m_adc = 0; m_irq = 0; m_prev = 0;
        end else begin
            m_prev = cnt_i[9:6];
            if (standby_i) begin
                m_reg = 0; m_adc = 0; m_irq = 0;
            end else begin
                m_adc = adc_n;
                if (irq_set)        m_irq = 1;
                else if (irq_clr_i) m_irq = 0;
                if (ctrl_wr_en) m_reg = ctrl_wr_data;
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cycles++;
        vectors++;
        if (adc_start_o) adc_pulses++;
        if (ctrl_rd_data !== m_reg || adc_start_o !== m_adc || irq_o !== m_irq) begin
            errors++;
            $display("FAIL %s: rd=%h adc=%b irq=%b expected rd=%h adc=%b irq=%b (cnt=%h)",
                     cur_req, ctrl_rd_data, adc_start_o, irq_o, m_reg, m_adc, m_irq, cnt_i);
        end
        ctrl_wr_en = 0; irq_clr_i = 0; standby_i = 0; rst = 0;
    endtask

    task automatic wr(input bit [7:0] d);
        ctrl_wr_en = 1; ctrl_wr_data = d; cyc();
    endtask

    task automatic expect_pulses(input int n, input string req);
        vectors++;
        if (adc_pulses != n) begin
            errors++;
            $display("FAIL %s: pulses=%0d expected=%0d", req, adc_pulses, n);
        end
        adc_pulses = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1"; rst = 1; cyc(); rst = 1; cyc();
        wr(8'hA5); wr(8'h5A); wr(8'h00); cyc();

        // R2 and R10: bit 6 sweep, one pulse per rise only
        cur_req = "R2/R10"; wr(8'h10); adc_pulses = 0;
        for (int i = 0; i < 300; i++) begin cnt_i = 16'(i); cyc(); end
        expect_pulses(2, "R10");

        // R4: edges with enables off
        cur_req = "R4"; wr(8'h00);
        for (int i = 0; i < 300; i++) begin cnt_i = 16'(i); cyc(); end
        expect_pulses(0, "R4");

        // R3 and R6: interrupt from bit 9, sticky, clear priority
        cur_req = "R3"; wr(8'h08); cnt_i = 16'h01F0; cyc(); cnt_i = 16'h0200; cyc();
        cur_req = "R6"; repeat (5) cyc();
        irq_clr_i = 1; cyc(); cyc();
        cnt_i = 16'h0000; cyc();
        cnt_i = 16'h0200; irq_clr_i = 1; cyc(); cyc();
        irq_clr_i = 1; cyc();

        // R7: all four bits rise together
        cur_req = "R7"; wr(8'hF0); cnt_i = 16'h0000; cyc(); adc_pulses = 0;
        cnt_i = 16'h03C0; cyc(); cyc(); cyc();
        expect_pulses(1, "R7");

        // R8: write in the edge cycle uses old enables
        cur_req = "R8"; wr(8'h00); cnt_i = 16'h0000; cyc();
        cnt_i = 16'h0040; ctrl_wr_en = 1; ctrl_wr_data = 8'h10; cyc(); cyc();
        cnt_i = 16'h0000; cyc();
        cnt_i = 16'h0040; ctrl_wr_en = 1; ctrl_wr_data = 8'h00; cyc(); cyc();

        // R9: wrap with everything enabled
        cur_req = "R9"; wr(8'hFF); irq_clr_i = 1; cnt_i = 16'hFFFE; cyc();
        irq_clr_i = 1; cnt_i = 16'hFFFF; cyc(); adc_pulses = 0;
        cnt_i = 16'h0000; cyc(); cnt_i = 16'h0001; cyc(); cyc();
        expect_pulses(0, "R9");

        // R5: standby clears register and flag, blocks edges
        cur_req = "R5"; cnt_i = 16'h0000; cyc(); cnt_i = 16'h03C0; cyc(); cyc();
        standby_i = 1; cyc(); cnt_i = 16'h0000; cyc();
        cnt_i = 16'h03C0; standby_i = 1; cyc(); cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule